// File: doc/BRIEF.md
# Core Clock Divider Control Register

This block turns one fast PLL clock into clock enables for a microcontroller core and for the converter modulators. Software sets the core rate through an 8-bit control register on a simple write/read bus. A three-bit divider code picks a core rate of the PLL rate divided by a power of two, from 1 to 128. A modulator enable runs at the crystal rate, which is the PLL rate divided by 384. Both enables come from counters that start together at reset, so every modulator tick falls on a core tick at every core rate.

A fast-interrupt option runs the core at the full PLL rate while an interrupt is being serviced. Interrupt entry and return arrive as single-cycle strobes. A depth counter tracks nested entries, and the programmed rate comes back only after the outermost return. The register also shows a read-only PLL lock flag and the level of an external pin captured while reset is held. It drives an oscillator power-down control output. A new divider code is applied only at the 128-cycle boundary of the core counter, so a code change never produces a shortened core period.

Top module: `coreclk_divctl`

## Requirements
- R1: After reset the writable fields read as oscillator power-down 0, fast-interrupt enable 0 and divider code 3, so bits 3..0 read 0x3 and the core rate is PLL/8. A write stores bit 7, bit 3 and bits 2..0 of the write data.
- R2: With no override active and divider code N applied, `core_ce` is high for one cycle whenever the low N bits of a free-running counter are all ones. The counter counts PLL cycles since reset. This gives pulses every 2^N cycles for N = 0..7.
- R3: A new divider code takes effect on the PLL cycle after the free-running counter reaches 127. Until then the previous code applies, so no core period shorter than both the old and the new period is produced.
- R4: `mod_ce` is high for one cycle in every 384, on the cycle where the count since reset modulo 384 is 383. Every `mod_ce` pulse coincides with a `core_ce` pulse.
- R5: With bit 3 set and at least one interrupt open, `fast_active` is high and `core_ce` is high on every cycle, whatever the divider code.
- R6: Entry and return strobes move a nesting depth up and down, and a strobe pair in the same cycle leaves it unchanged. The override is released only when the depth returns to zero. A return at depth zero is ignored.
- R7: With bit 3 clear, interrupt entries never raise `fast_active` and do not change the `core_ce` pattern.
- R8: Bit 6 reads the `pll_locked` input, and writes to bit 6 have no effect.
- R9: Bit 5 is reserved and always reads 0, even after a write of 1.
- R10: Bit 4 reads the level of `ext_pin` captured while reset was asserted. Later changes on the pin and writes to bit 4 have no effect.
- R11: Bit 7 drives `osc_pd` and reads back the value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PLL clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_pin | input | 1 | External pin, captured while reset is held |
| pll_locked | input | 1 | Lock indication from the PLL |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data |
| irq_enter | input | 1 | Interrupt entry strobe |
| irq_return | input | 1 | Interrupt return strobe |
| core_ce | output | 1 | Core clock enable pulse |
| mod_ce | output | 1 | Modulator clock enable pulse |
| osc_pd | output | 1 | Oscillator power-down control |
| fast_active | output | 1 | Fast-interrupt override in force |

## Verification
The hardest case to reach is a code change that lands partway through a 128-cycle counter window. The old pattern must continue up to the boundary and the new one start exactly after it. The stimulus writes code 7 while code 0 is running, and code 0 while code 7 is running, at a chosen count. The bench keeps its own cycle count and its own record of the programmed and applied codes, and checks `core_ce` on every cycle against that record. Nested interrupt strobes are driven in the same way, both with the fast-interrupt bit set and with it clear. This covers simultaneous entry and return and a return at depth zero.

// File: rtl/ccd_pkg.sv
// Package: register layout and control field type for the core clock divider.
// Assumes an 8-bit register whose bit positions are fixed by software.
package ccd_pkg;
    localparam int REG_W    = 8;
    localparam int CODE_W   = 3;
    localparam int BIT_OPD  = 7;
    localparam int BIT_LOCK = 6;
    localparam int BIT_RSVD = 5;
    localparam int BIT_PIN  = 4;
    localparam int BIT_FIRQ = 3;

    typedef struct packed {
        logic              opd;
        logic              firq;
        logic [CODE_W-1:0] code;
    } ctl_t;
endpackage

// File: rtl/ccd_ctlreg.sv
// Control register: holds the writable fields, captures the external pin
// while reset is held, and composes the read view. Assumes a write strobe
// that is valid for one clock and a read path that needs no strobe.
module ccd_ctlreg
    import ccd_pkg::*;
#(
    parameter logic [CODE_W-1:0] RST_CODE = 3'd3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_pin,
    input  logic             pll_locked,
    input  logic             bus_we,
    input  logic [REG_W-1:0] bus_wdata,
    output ctl_t             ctl,
    output logic [REG_W-1:0] bus_rdata
);
    logic pin_q;

    // Writable fields: reset value, then load from the bus on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl.opd  <= 1'b0;
            ctl.firq <= 1'b0;
            ctl.code <= RST_CODE;
        end else if (bus_we) begin
            ctl.opd  <= bus_wdata[BIT_OPD];
            ctl.firq <= bus_wdata[BIT_FIRQ];
            ctl.code <= bus_wdata[CODE_W-1:0];
        end
    end

    // Pin capture: follows the pin only while reset is asserted.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= ext_pin;
    end

    // Read view: live lock flag, reserved bit forced low.
    always_comb begin
        bus_rdata                = '0;
        bus_rdata[BIT_OPD]       = ctl.opd;
        bus_rdata[BIT_LOCK]      = pll_locked;
        bus_rdata[BIT_RSVD]      = 1'b0;
        bus_rdata[BIT_PIN]       = pin_q;
        bus_rdata[BIT_FIRQ]      = ctl.firq;
        bus_rdata[CODE_W-1:0]    = ctl.code;
    end

    // R1
    wr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |=> (ctl.code == $past(bus_wdata[CODE_W-1:0]))
                && (ctl.firq == $past(bus_wdata[BIT_FIRQ]))
                && (ctl.opd  == $past(bus_wdata[BIT_OPD])));

    // R10
    pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(pin_q));
endmodule

// File: rtl/ccd_coreclk.sv
// Core enable generator: a free-running counter of 2^CODE_W-1 bits. The
// applied code is refreshed from the requested code only when the counter
// is all ones, so every period is a whole power of two. A force input
// makes the enable high on every cycle.
module ccd_coreclk
    import ccd_pkg::*;
#(
    parameter logic [CODE_W-1:0] RST_CODE = 3'd3,
    localparam int CNT_W = (1 << CODE_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_req,
    input  logic              force_full,
    output logic              core_ce
);
    logic [CNT_W-1:0]  cnt;
    logic [CODE_W-1:0] act_code;
    logic [CNT_W-1:0]  mask;
    logic              wrap;

    // Free-running PLL cycle counter, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end

    assign wrap = &cnt;

    // Applied code: adopts the requested code only at the counter wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)    act_code <= RST_CODE;
        else if (wrap) act_code <= code_req;
    end

    // Low-bit mask selected by the applied code.
    always_comb mask = ~({CNT_W{1'b1}} << act_code);

    // Enable: pulse on all-ones low bits, or every cycle under override.
    always_comb core_ce = force_full || ((cnt & mask) == mask);

    // R3
    code_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(act_code)) |-> $past(wrap));

    // R2
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_ce && !force_full && act_code != '0 && !wrap)
            |=> (!core_ce || force_full));
endmodule

// File: rtl/ccd_modtick.sv
// Modulator enable: a modulo-RATIO counter that pulses on its last count.
// Assumes RATIO is a multiple of the core counter span so the two align.
module ccd_modtick #(
    parameter int RATIO = 384,
    localparam int MW = $clog2(RATIO)
) (
    input  logic clk,
    input  logic rst_n,
    output logic mod_ce
);
    localparam logic [MW-1:0] LAST = MW'(RATIO - 1);
    logic [MW-1:0] cnt;

    // Modulo counter, restarting at zero after its last count.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (cnt == LAST)  cnt <= '0;
        else                   cnt <= cnt + 1'b1;
    end

    // Single-cycle pulse on the last count of each span.
    always_comb mod_ce = (cnt == LAST);
endmodule

// File: rtl/ccd_irqdepth.sv
// Interrupt nesting tracker: counts open interrupts and asserts the
// override while the fast-interrupt bit is set and any interrupt is open.
// Assumes single-cycle strobes; the depth saturates at its maximum.
module ccd_irqdepth #(
    parameter int DEPTH_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_enter,
    input  logic irq_return,
    input  logic firq_en,
    output logic fast_active
);
    localparam logic [DEPTH_W-1:0] DMAX = '1;
    logic [DEPTH_W-1:0] depth;

    // Depth: up on entry, down on return, unchanged on a pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            depth <= '0;
        end else if (irq_enter && !irq_return && depth != DMAX) begin
            depth <= depth + 1'b1;
        end else if (irq_return && !irq_enter && depth != '0) begin
            depth <= depth - 1'b1;
        end
    end

    // Override in force while enabled and any interrupt is open.
    always_comb fast_active = firq_en && (depth != '0);

    // R6
    depth_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_return && !irq_enter && depth == DEPTH_W'(1)) |=> !fast_active);
endmodule

// File: rtl/coreclk_divctl.sv
// Top: core clock divider control register. Wires the control register,
// core enable generator, modulator tick and interrupt tracker together.
// Assumes MOD_RATIO is a multiple of 128, so the modulator tick lands on
// a core counter wrap.
module coreclk_divctl
    import ccd_pkg::*;
#(
    parameter int MOD_RATIO = 384,
    parameter int DEPTH_W   = 4,
    parameter logic [2:0] RST_CODE = 3'd3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ext_pin,
    input  logic       pll_locked,
    input  logic       bus_we,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       irq_enter,
    input  logic       irq_return,
    output logic       core_ce,
    output logic       mod_ce,
    output logic       osc_pd,
    output logic       fast_active
);
    ctl_t ctl;

    ccd_ctlreg #(.RST_CODE(RST_CODE)) u_reg (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .pll_locked(pll_locked),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .ctl(ctl), .bus_rdata(bus_rdata)
    );

    ccd_irqdepth #(.DEPTH_W(DEPTH_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .irq_enter(irq_enter),
        .irq_return(irq_return), .firq_en(ctl.firq), .fast_active(fast_active)
    );

    ccd_coreclk #(.RST_CODE(RST_CODE)) u_core (
        .clk(clk), .rst_n(rst_n), .code_req(ctl.code),
        .force_full(fast_active), .core_ce(core_ce)
    );

    ccd_modtick #(.RATIO(MOD_RATIO)) u_mod (
        .clk(clk), .rst_n(rst_n), .mod_ce(mod_ce)
    );

    assign osc_pd = ctl.opd;

    // R4
    mod_on_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mod_ce |-> core_ce);

    // R5
    fast_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fast_active |-> core_ce);

    // R8
    lock_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && $stable(pll_locked)) |=> (bus_rdata[BIT_LOCK] == $past(pll_locked)));
endmodule

// File: tb/tb_coreclk_divctl.sv
`timescale 1ns/1ps
// Bench: keeps its own cycle count, register model and nesting depth, and
// checks every output on every cycle against them.
module tb_coreclk_divctl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_pin = 1'b1, pll_locked = 1'b0, bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic irq_enter = 1'b0, irq_return = 1'b0;
    logic core_ce, mod_ce, osc_pd, fast_active;

    int n = 0;
    int checks = 0, fails = 0;
    int m_req = 3, m_act = 3, m_depth = 0;
    bit m_firq = 0, m_opd = 0, m_pin = 1;
    int last_ce = -1, min_gap = 1000;

    always #10 clk = ~clk;

    always @(posedge clk) n <= rst_n ? n + 1 : 0;

    coreclk_divctl dut (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .pll_locked(pll_locked),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_enter(irq_enter), .irq_return(irq_return), .core_ce(core_ce),
        .mod_ce(mod_ce), .osc_pd(osc_pd), .fast_active(fast_active)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at n=%0d: actual %0d expected %0d", tag, n, act, exp);
        end
    endtask

    // One cycle: check all outputs at the negedge, then advance the model.
    task automatic step();
        int mask;
        bit efast, ece;
        @(negedge clk);
        bus_we = 1'b0; irq_enter = 1'b0; irq_return = 1'b0;
        mask = (1 << m_act) - 1;
        efast = m_firq && (m_depth > 0);
        ece = efast || ((n & mask) == mask);
        chk(fast_active == efast, m_firq ? "R5" : "R7", fast_active, efast);
        chk(core_ce == ece, efast ? "R5" : "R2", core_ce, ece);
        chk(mod_ce == ((n % 384) == 383), "R4", mod_ce, (n % 384) == 383);
        chk(bus_rdata[3:0] == {m_firq, 3'(m_req)}, "R1", bus_rdata[3:0], {m_firq, 3'(m_req)});
        chk(bus_rdata[6] == pll_locked, "R8", bus_rdata[6], pll_locked);
        chk(bus_rdata[5] == 1'b0, "R9", bus_rdata[5], 0);
        chk(bus_rdata[4] == m_pin, "R10", bus_rdata[4], m_pin);
        chk(bus_rdata[7] == m_opd && osc_pd == m_opd, "R11", osc_pd, m_opd);
        if (core_ce) begin
            if (last_ce >= 0 && (n - last_ce) < min_gap) min_gap = n - last_ce;
            last_ce = n;
        end
        if ((n % 128) == 127) m_act = m_req;
    endtask

    task automatic wr(input logic [7:0] v);
        bus_we = 1'b1; bus_wdata = v;
        m_req = v[2:0]; m_firq = v[3]; m_opd = v[7];
        step();
    endtask

    task automatic irq(input bit en, input bit rt);
        irq_enter = en; irq_return = rt;
        if (en && !rt && m_depth < 15) m_depth++;
        else if (rt && !en && m_depth > 0) m_depth--;
        step();
    endtask

    task automatic run(input int k);
        for (int i = 0; i < k; i++) step();
    endtask

    task automatic to_count(input int r);
        while ((n % 128) != r) step();
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        fails++; checks++;
        $display("FAIL watchdog: actual hung expected done");
        finish_up();
    end

    initial begin
        // Reset with the pin high; the pin drops afterwards (R10).
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        ext_pin = 1'b0;
        // R1: reset value, default PLL/8 pattern.
        chk(bus_rdata == 8'h13, "R1", bus_rdata, 8'h13);
        run(200);
        // R8: lock follows the input; writing bit 6 has no effect.
        pll_locked = 1'b1; run(3);
        pll_locked = 1'b0; wr(8'h43); run(3);
        // R9: a write of the reserved bit reads back 0. R10: bit 4 not writable.
        wr(8'h23); wr(8'h03); run(2);
        // R2/R4: sweep every divider code over a full modulator span.
        for (int c = 0; c < 8; c++) begin
            to_count(40);
            wr(8'(c));
            to_count(127); step();
            run(384);
        end
        // R3: code 0 to 7 mid-window; gap must stay 1 until the wrap, then 128.
        wr(8'h00); to_count(127); step();
        to_count(40); wr(8'h07);
        last_ce = -1; min_gap = 1000;
        run(300);
        chk(min_gap == 1, "R3", min_gap, 1);
        to_count(40); wr(8'h00); run(100);
        chk(core_ce == 1'b1, "R3", core_ce, 1);
        // R3: 7 back to 3 mid-window; no gap under 8 after the old pattern.
        wr(8'h07); to_count(127); step();
        to_count(60); wr(8'h03);
        last_ce = -1; min_gap = 1000;
        run(200);
        chk(min_gap == 8, "R3", min_gap, 8);
        // R5/R6: nested entries with the override enabled at code 7.
        wr(8'h0F);
        irq(1, 0); run(3);
        irq(1, 0); irq(1, 1); run(2);
        irq(0, 1); run(2);
        chk(fast_active == 1'b1, "R6", fast_active, 1);
        irq(0, 1); run(2);
        chk(fast_active == 1'b0, "R6", fast_active, 0);
        irq(0, 1); run(130);
        chk(fast_active == 1'b0, "R6", fast_active, 0);
        // R7: entries with the override disabled leave the pattern alone.
        wr(8'h07);
        irq(1, 0); run(140);
        chk(fast_active == 1'b0, "R7", fast_active, 0);
        // R5: enabling with an interrupt already open forces full rate.
        wr(8'h0F); run(5);
        chk(fast_active == 1'b1 && core_ce == 1'b1, "R5", core_ce, 1);
        irq(0, 1); run(130);
        // R11: oscillator power-down bit drives the output.
        wr(8'h83); run(3);
        wr(8'h03); run(3);
        // R10: second reset with the pin low captures 0.
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1; ext_pin = 1'b1;
        m_pin = 0; m_req = 3; m_act = 3; m_firq = 0; m_opd = 0; m_depth = 0;
        run(400);
        finish_up();
    end
endmodule